// File: doc/BRIEF.md
# Port Status LED Pattern Generator

This block turns the state of a single-port power sequencer into a blink pattern on one active-low status LED. While the port searches for a powered device, the LED gives a short flash at the start of every detection cycle. Each cycle lasts about 320 ms, so the flashes come roughly three times per second and stay in phase with the search. Once power is applied to the port, the LED stays on. When a fault is reported, the LED flashes at 10 Hz.

The sequencer supplies a two-bit state code, a one-cycle pulse at the start of each detection cycle, a 1 ms tick and a latched recovery policy. Under the auto-restart policy the fault flashing stops after 2 s. Under the wait-for-reset policy it goes on until reset. The pin shares its function with a configuration input that is read at power-up. For that reason the output enable stays low until the configuration sample has been taken.

Top module: `port_led_pattern`

## Requirements
- R1: `led_n` is active-low: 0 lights the LED and 1 turns it off. `led_n` is registered, and shows the inputs sampled at the previous rising clock edge.
- R2: In the searching state (`port_state` = 2'b01), the LED is lit from a `cycle_start` pulse for the next SRCH_ON_MS ticks (default 160) and is dark for the rest of the cycle. A new pulse restarts the lit phase at once, even if the cycle is not finished.
- R3: In the powered state (`port_state` = 2'b10), the LED is lit continuously.
- R4: On entry to the fault state (`port_state` = 2'b11, previous state not 2'b11), the LED is lit at once. It then alternates ERR_HALF_MS ticks lit and ERR_HALF_MS ticks dark (default 50), counted from entry.
- R5: With `hold_until_reset` = 0, the fault flashing ends after ERR_HOLD_MS ticks (default 2000) from entry, and the LED then stays dark. With `hold_until_reset` = 1, the flashing continues until reset.
- R6: In the idle state (`port_state` = 2'b00), the LED is dark. Leaving the searching state discards the search phase. On a return to searching, the LED stays dark until the next `cycle_start`.
- R7: While `rst_n` is low, `led_n` is 1 and `led_oe` is 0.
- R8: `led_oe` follows `cfg_done` one clock later, so the pin is not driven until the configuration sample is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| cfg_done | input | 1 | High once the power-up configuration sample is taken |
| port_state | input | 2 | Sequencer state: 00 idle, 01 searching, 10 powered, 11 fault |
| cycle_start | input | 1 | One-cycle pulse at the start of each detection cycle |
| hold_until_reset | input | 1 | Latched recovery policy: 1 keeps fault flashing until reset |
| led_n | output | 1 | Active-low LED drive |
| led_oe | output | 1 | Output enable for the shared pin |

## Verification
The searching state is tested with regular cycle pulses 320 ticks apart, with one pulse that arrives early, and with a stretch of searching that has no pulse. These three cases separate phase locking to the pulse from a free-running blink. The fault state is tested once under each recovery policy and run past the 2000-tick point, which separates a bounded burst from an unbounded one. Idle, powered, a return from idle to searching, and reset applied during fault flashing show that each state code selects its own pattern and that no stale phase carries over. A behavioural model counts milliseconds with plain integers and is compared with the outputs on every clock.

// File: rtl/port_led_pkg.sv
package port_led_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'b00,
    PS_SEARCH  = 2'b01,
    PS_POWERED = 2'b10,
    PS_FAULT   = 2'b11
  } port_state_e;
endpackage

// File: rtl/led_search_phase.sv
// Lit window at the start of each detection cycle, restarted by every pulse.
module led_search_phase #(
  parameter int ON_MS = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_search,
  input  logic cycle_start,
  output logic lit_d
);
  localparam int CW = $clog2(ON_MS + 1);
  localparam logic [CW-1:0] ON_LIM = CW'(ON_MS);

  logic [CW-1:0] since_q, since_d;
  logic          valid_q, valid_d;

  always_comb begin
    valid_d = cycle_start | (in_search & valid_q);
    if (cycle_start)
      since_d = '0;
    else if (tick && since_q < ON_LIM)
      since_d = since_q + 1'b1;
    else
      since_d = since_q;
    lit_d = in_search & valid_d & (since_d < ON_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= ON_LIM;
      valid_q <= 1'b0;
    end else begin
      since_q <= since_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/led_fault_phase.sv
// Square-wave fault flash from entry, optionally bounded in length.
module led_fault_phase #(
  parameter int HALF_MS = 50,
  parameter int HOLD_MS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_fault,
  input  logic fault_entry,
  input  logic hold_until_reset,
  output logic lit_d
);
  localparam int SW = $clog2(2 * HALF_MS);
  localparam int MW = $clog2(HOLD_MS + 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(2 * HALF_MS - 1);
  localparam logic [SW-1:0] SLOT_HALF = SW'(HALF_MS);
  localparam logic [MW-1:0] MS_LIM    = MW'(HOLD_MS);

  logic [SW-1:0] slot_q, slot_d;
  logic [MW-1:0] ms_q, ms_d;

  always_comb begin
    slot_d = slot_q;
    ms_d   = ms_q;
    if (fault_entry) begin
      slot_d = '0;
      ms_d   = '0;
    end else if (in_fault && tick) begin
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      ms_d   = (ms_q == MS_LIM) ? ms_q : ms_q + 1'b1;
    end
    lit_d = in_fault & (slot_d < SLOT_HALF) & (hold_until_reset | (ms_d < MS_LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ms_q   <= '0;
    end else begin
      slot_q <= slot_d;
      ms_q   <= ms_d;
    end
  end
endmodule

// File: rtl/port_led_pattern.sv
module port_led_pattern
  import port_led_pkg::*;
#(
  parameter int SRCH_ON_MS  = 160,
  parameter int ERR_HALF_MS = 50,
  parameter int ERR_HOLD_MS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       cfg_done,
  input  logic [1:0] port_state,
  input  logic       cycle_start,
  input  logic       hold_until_reset,
  output logic       led_n,
  output logic       led_oe
);
  port_state_e st, prev_q;
  logic in_search, in_fault, in_power, fault_entry;
  logic srch_lit, fault_lit, lit_d;

  assign st          = port_state_e'(port_state);
  assign in_search   = (st == PS_SEARCH);
  assign in_fault    = (st == PS_FAULT);
  assign in_power    = (st == PS_POWERED);
  assign fault_entry = in_fault & (prev_q != PS_FAULT);

  led_search_phase #(.ON_MS(SRCH_ON_MS)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1ms),
    .in_search  (in_search),
    .cycle_start(cycle_start),
    .lit_d      (srch_lit)
  );

  led_fault_phase #(.HALF_MS(ERR_HALF_MS), .HOLD_MS(ERR_HOLD_MS)) u_fault (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick_1ms),
    .in_fault        (in_fault),
    .fault_entry     (fault_entry),
    .hold_until_reset(hold_until_reset),
    .lit_d           (fault_lit)
  );

  assign lit_d = srch_lit | fault_lit | in_power;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_n  <= 1'b1;
      led_oe <= 1'b0;
      prev_q <= PS_IDLE;
    end else begin
      led_n  <= ~lit_d;
      led_oe <= cfg_done;
      prev_q <= st;
    end
  end
endmodule

// File: rtl/port_led_pattern_chk.sv
module port_led_pattern_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] port_state,
  input logic       cycle_start,
  input logic       cfg_done,
  input logic       fault_entry,
  input logic       led_n,
  input logic       led_oe
);
  AST_POWERED_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    port_state == 2'b10 |=> !led_n); // R3
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    port_state == 2'b00 |=> led_n); // R6
  AST_SEARCH_PULSE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (port_state == 2'b01 && cycle_start) |=> !led_n); // R2
  AST_FAULT_ENTRY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_entry |=> !led_n); // R4
  AST_OE_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> led_oe); // R8
  AST_OE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> !led_oe); // R8
endmodule

bind port_led_pattern port_led_pattern_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_state (port_state),
  .cycle_start(cycle_start),
  .cfg_done   (cfg_done),
  .fault_entry(fault_entry),
  .led_n      (led_n),
  .led_oe     (led_oe)
);

// File: tb/port_led_pattern_test.sv
module port_led_pattern_test;
  localparam int SRCH_ON = 160;
  localparam int HALF    = 50;
  localparam int HOLD    = 2000;

  logic       clk = 0, rst_n = 1, tick_1ms = 0, cfg_done = 0;
  logic       cycle_start = 0, hold_until_reset = 0;
  logic [1:0] port_state = 2'b00;
  logic       led_n, led_oe;

  int checks = 0, errors = 0, tick_div = 0, lit_seen = 0;
  bit done = 0;

  int         m_since = SRCH_ON;
  bit         m_valid = 0;
  int         m_el = 0;
  logic [1:0] m_prev = 2'b00;
  bit         exp_led = 1, exp_oe = 0;

  always #10 clk = ~clk;

  port_led_pattern uut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .cfg_done(cfg_done),
    .port_state(port_state), .cycle_start(cycle_start),
    .hold_until_reset(hold_until_reset), .led_n(led_n), .led_oe(led_oe)
  );

  task automatic check_bit(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'b00:   return "R6 idle dark";
      2'b01:   return "R2 search flash";
      2'b10:   return "R3 powered lit";
      default: return "R4/R5 fault flash";
    endcase
  endfunction

  // Behavioural model, evaluated once per rising edge.
  task automatic model_edge();
    bit lit;
    if (!rst_n) begin
      m_since = SRCH_ON; m_valid = 0; m_el = 0; m_prev = 2'b00;
      exp_led = 1; exp_oe = 0;
    end else begin
      if (cycle_start) begin m_since = 0; m_valid = 1; end
      else begin
        if (tick_1ms && m_since < SRCH_ON) m_since++;
        if (port_state != 2'b01) m_valid = 0;
      end
      if (port_state == 2'b11 && m_prev != 2'b11) m_el = 0;
      else if (port_state == 2'b11 && tick_1ms) m_el++;
      lit = (port_state == 2'b10)
         || (port_state == 2'b01 && m_valid && m_since < SRCH_ON)
         || (port_state == 2'b11 && (m_el % (2*HALF)) < HALF
             && (hold_until_reset || m_el < HOLD));
      m_prev  = port_state;
      exp_led = !lit;
      exp_oe  = cfg_done;
    end
  endtask

  task automatic step(input bit cs);
    cycle_start = cs;
    tick_1ms = (tick_div == 3);
    tick_div = (tick_div + 1) % 4;
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    check_bit(led_n, exp_led, rst_n ? tag_for(port_state) : "R7 reset dark");
    check_bit(led_oe, exp_oe, rst_n ? "R8 output enable" : "R7 reset no drive");
    if (led_n === 1'b0) lit_seen++;
    cycle_start = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  initial begin
    #5 rst_n = 0;
    @(negedge clk);
    run(3);
    check_bit(led_n, 1'b1, "R7 dark in reset");
    check_bit(led_oe, 1'b0, "R7 undriven in reset");
    rst_n = 1;
    run(4);
    check_bit(led_oe, 1'b0, "R8 undriven before sample");
    cfg_done = 1;
    step(0);
    check_bit(led_oe, 1'b1, "R8 driven after sample");
    // searching, no pulse yet
    port_state = 2'b01;
    run(200);
    check_bit(led_n, 1'b1, "R6 search dark before pulse");
    step(1);
    check_bit(led_n, 1'b0, "R1 lit drives low on pulse");
    for (int c = 0; c < 3; c++) begin
      run(320*4 - 1);
      step(1);
    end
    run(100*4);
    step(1);
    check_bit(led_n, 1'b0, "R2 early pulse restarts lit phase");
    run(1400);
    // powered
    port_state = 2'b10;
    run(400);
    check_bit(led_n, 1'b0, "R3 powered steady");
    // fault, auto restart
    hold_until_reset = 0;
    port_state = 2'b11;
    step(0);
    check_bit(led_n, 1'b0, "R4 lit on fault entry");
    run(2100*4);
    check_bit(led_n, 1'b1, "R5 auto policy stops flashing");
    // idle, then search again
    port_state = 2'b00;
    run(20);
    port_state = 2'b01;
    run(100);
    check_bit(led_n, 1'b1, "R6 resumed search dark until pulse");
    step(1);
    run(400);
    // fault, wait-for-reset policy
    hold_until_reset = 1;
    port_state = 2'b11;
    run(2005*4);
    lit_seen = 0;
    run(400);
    checks++;
    if (lit_seen == 0) begin
      errors++;
      $display("FAIL R5 hold policy: got %0d lit cycles expected >0", lit_seen);
    end
    rst_n = 0;
    run(3);
    check_bit(led_n, 1'b1, "R7 reset ends held flashing");
    port_state = 2'b00;
    rst_n = 1;
    run(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule